// File: doc/BRIEF.md
# Page-Based Receive DMA Manager

This block moves a stream of 32-bit data words into host memory without processor help for each word. Host software keeps a queue of empty, page-aligned memory pages filled with their base addresses. The block draws one page at a time from that queue. It steers every incoming word to the next 4-byte location of the current page, and it issues the writes as short bursts on a simple master write port. That port stands in for the real system bus.

A page is closed in one of two ways: its last word is written, or the incoming word carries the end-of-block marker. When a page closes, the block places a report in a second queue that software drains. The report holds the page base address and a status word giving the byte count, a last-page-of-block flag and an error flag. A block longer than one page continues on the next free page, so software reassembles it from consecutive reports.

No data is dropped. With no free page in hand the receive side is held off. With the report queue full, the block will not open a new page.

Top module: `rxdma_top`

## Requirements
- R1: A synchronous active-low reset empties both queues and returns the block to waiting. While in reset and after it: rx_ready=0, mw_valid=0, rdy_valid=0 and free_full=0. A page partly filled at the time of reset produces no report, and addresses queued before the reset are never used.
- R2: Free page addresses are used in the order they were pushed. The free queue holds FREE_DEPTH entries, and free_full is high when it is full. A push while free_full is high is ignored, so that address is never used.
- R3: While the block holds no free page, rx_ready stays low and no master write occurs. Words offered during that time are accepted later, with none lost.
- R4: Each accepted receive word (rx_valid and rx_ready high at a clock edge) produces exactly one master beat in the same cycle. The beat has the same data, at address page_base + 4 × (index of the word within the page). rx_ready is never high while mw_ready is low.
- R5: mw_last is high on a beat in any of three cases: the beat completes an aligned group of BURST_WORDS words (default 8) within the page, it is the last word of the page, or it carries the end-of-block marker. A burst never spans two pages.
- R6: When the last word of a page (PAGE_BYTES/4 words, default 1024) is accepted, the block pushes a report with the page base and a status word. Status bits [23:0] hold the byte count (PAGE_BYTES for a full page). Bit 31 is the last-page flag, set only if that word also ended the block. Bit 30 is the error flag. Bits [29:24] are zero.
- R7: A word with rx_last high closes the current page at once. Its report gives byte count 4 × words written with bit 31 set. The following block starts at offset 0 of the next free page.
- R8: Status bit 30 is set when at least one word written to that page arrived with rx_err high. It starts clear on every new page.
- R9: The report queue holds RDY_DEPTH entries. While it is full, the block does not open a new page, so rx_ready stays low. The block resumes once software pops an entry with rdy_pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| free_push | input | 1 | Push a free page address |
| free_addr | input | 32 | Page base address to push (page aligned) |
| free_full | output | 1 | Free page queue is full |
| rx_valid | input | 1 | Receive word available |
| rx_ready | output | 1 | Block accepts the receive word |
| rx_data | input | 32 | Receive data word |
| rx_last | input | 1 | Word is the last of its data block |
| rx_err | input | 1 | Word was received with an error |
| mw_valid | output | 1 | Master write beat valid |
| mw_ready | input | 1 | Bus side accepts the beat |
| mw_addr | output | 32 | Byte address of the beat |
| mw_data | output | 32 | Data of the beat |
| mw_last | output | 1 | Final beat of the current burst |
| rdy_valid | output | 1 | A page report is available |
| rdy_pop | input | 1 | Remove the head report |
| rdy_addr | output | 32 | Base address of the reported page |
| rdy_status | output | 32 | Status of the reported page |

## Verification
The address and burst assertions assume that every base address pushed into the free queue is a multiple of PAGE_BYTES. They also assume that PAGE_BYTES is a multiple of four times BURST_WORDS. The bench pushes only page-aligned bases and keeps the default sizes, which meet both conditions. The master port is allowed to stall at any time, so the bench drives mw_ready both constantly high and in a repeating stall pattern. The receive side is never assumed to hold data stable while stalled, and the bench only changes a word after it has been accepted.

// File: rtl/rxdma_pkg.sv
// Shared types for the page-based receive DMA manager.
// Assumes a 32-bit data path and 32-bit byte addresses.
package rxdma_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CNT_W  = 24;

    // Status word: last flag in bit 31, error flag in bit 30, byte count in [23:0].
    typedef struct packed {
        logic             last;
        logic             err;
        logic [5:0]       rsvd;
        logic [CNT_W-1:0] bytes;
    } pg_status_t;

    // One entry of the report queue.
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        pg_status_t        status;
    } pg_report_t;

    typedef enum logic {
        ENG_WAIT = 1'b0,
        ENG_FILL = 1'b1
    } eng_state_t;

endpackage

// File: rtl/rxdma_fifo.sv
// Synchronous first-in first-out queue with show-ahead output.
// A push while full and a pop while empty are ignored.
// Assumes DEPTH >= 2. The storage itself is not reset; only the pointers and the fill count are.
module rxdma_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (fill == CNT_W'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    // Write the incoming entry into storage.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= din;
        end
    end

    // Advance pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

    a_r2_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (fill == $past(fill)));

    a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

endmodule

// File: rtl/rxdma_page_engine.sv
// Page fill engine: takes one free page at a time and passes accepted receive
// words to the master write port at consecutive word addresses of that page.
// It frames bursts and reports each closed page.
// Assumes page bases are multiples of PAGE_BYTES, and PAGE_BYTES is a multiple
// of 4*BURST_WORDS, with BURST_WORDS a power of two of at least 2.
module rxdma_page_engine
    import rxdma_pkg::*;
#(
    parameter int unsigned PAGE_BYTES  = 4096,
    parameter int unsigned BURST_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              free_valid,
    input  logic [ADDR_W-1:0] free_base,
    output logic              free_take,
    input  logic              rdy_full,
    output logic              rdy_push,
    output pg_report_t        rdy_entry,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [WORD_W-1:0] mw_data,
    output logic              mw_last
);

    localparam int unsigned PAGE_WORDS = PAGE_BYTES / 4;
    localparam int unsigned IDX_W      = $clog2(PAGE_WORDS);
    localparam int unsigned BST_W      = $clog2(BURST_WORDS);

    eng_state_t        state;
    logic [ADDR_W-1:0] page_base;
    logic [IDX_W-1:0]  word_idx;
    logic              err_acc;
    logic              beat;
    logic              page_end;
    logic              burst_end;
    logic              close;
    logic [IDX_W:0]    words_done;

    // Open a page only when a free page exists and a report slot is guaranteed.
    assign free_take = (state == ENG_WAIT) && free_valid && !rdy_full;

    // Pass-through handshake between receive stream and master port.
    assign rx_ready  = (state == ENG_FILL) && mw_ready;
    assign mw_valid  = (state == ENG_FILL) && rx_valid;
    assign mw_data   = rx_data;
    assign mw_addr   = page_base + ADDR_W'({word_idx, 2'b00});
    assign beat      = mw_valid && mw_ready;

    // Burst and page boundaries from the word index.
    assign page_end  = (word_idx == IDX_W'(PAGE_WORDS - 1));
    assign burst_end = &word_idx[BST_W-1:0];
    assign mw_last   = page_end || burst_end || rx_last;
    assign close     = beat && (page_end || rx_last);

    // Build the report for the page being closed.
    assign words_done             = {1'b0, word_idx} + (IDX_W + 1)'(1);
    assign rdy_push               = close;
    assign rdy_entry.base         = page_base;
    assign rdy_entry.status.last  = rx_last;
    assign rdy_entry.status.err   = err_acc || rx_err;
    assign rdy_entry.status.rsvd  = '0;
    assign rdy_entry.status.bytes = CNT_W'({words_done, 2'b00});

    // Page state: load a new base, advance the word index, close on boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ENG_WAIT;
            page_base <= '0;
            word_idx  <= '0;
            err_acc   <= 1'b0;
        end else begin
            case (state)
                ENG_WAIT: begin
                    if (free_take) begin
                        page_base <= free_base;
                        word_idx  <= '0;
                        err_acc   <= 1'b0;
                        state     <= ENG_FILL;
                    end
                end
                ENG_FILL: begin
                    if (close) begin
                        state <= ENG_WAIT;
                    end else if (beat) begin
                        word_idx <= word_idx + IDX_W'(1);
                        err_acc  <= err_acc || rx_err;
                    end
                end
                default: state <= ENG_WAIT;
            endcase
        end
    end

    a_r3_wait_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_WAIT) |-> (!rx_ready && !mw_valid));

    a_r3_take_needs_page: assert property (@(posedge clk) disable iff (!rst_n)
        free_take |-> free_valid);

    a_r4_rx_follows_mw: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> mw_ready);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !close) |=> (mw_addr == $past(mw_addr) + ADDR_W'(4)));

    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready) |=> $stable(mw_addr));

    a_r5_burst_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && (&mw_addr[BST_W+1:2])) |-> mw_last);

    a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_push |-> ((rdy_entry.status.bytes != '0) &&
                      (rdy_entry.status.bytes <= CNT_W'(PAGE_BYTES))));

    a_r7_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && rx_last) |=> (!rx_ready && !mw_valid));

    a_r9_report_room: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_push |-> !rdy_full);

endmodule

// File: rtl/rxdma_top.sv
// Page-based receive DMA manager top level.
// It links the free page queue and the page report queue to the page fill engine.
// Assumes host software pushes page-aligned bases and drains reports in order.
module rxdma_top
    import rxdma_pkg::*;
#(
    parameter int unsigned PAGE_BYTES  = 4096,
    parameter int unsigned BURST_WORDS = 8,
    parameter int unsigned FREE_DEPTH  = 8,
    parameter int unsigned RDY_DEPTH   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        free_push,
    input  logic [31:0] free_addr,
    output logic        free_full,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [31:0] rx_data,
    input  logic        rx_last,
    input  logic        rx_err,
    output logic        mw_valid,
    input  logic        mw_ready,
    output logic [31:0] mw_addr,
    output logic [31:0] mw_data,
    output logic        mw_last,
    output logic        rdy_valid,
    input  logic        rdy_pop,
    output logic [31:0] rdy_addr,
    output logic [31:0] rdy_status
);

    localparam int unsigned REP_W = $bits(pg_report_t);

    logic [ADDR_W-1:0] free_head;
    logic              free_empty;
    logic              free_take;
    logic              rdy_push;
    logic              rdy_full;
    logic              rdy_empty;
    pg_report_t        rdy_entry;
    pg_report_t        rdy_head;
    logic [REP_W-1:0]  rdy_dout;

    // Queue of empty host pages.
    rxdma_fifo #(
        .WIDTH (ADDR_W),
        .DEPTH (FREE_DEPTH)
    ) u_free_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (free_push),
        .din   (free_addr),
        .pop   (free_take),
        .dout  (free_head),
        .full  (free_full),
        .empty (free_empty)
    );

    // Page fill engine.
    rxdma_page_engine #(
        .PAGE_BYTES  (PAGE_BYTES),
        .BURST_WORDS (BURST_WORDS)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .free_valid (!free_empty),
        .free_base  (free_head),
        .free_take  (free_take),
        .rdy_full   (rdy_full),
        .rdy_push   (rdy_push),
        .rdy_entry  (rdy_entry),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_err     (rx_err),
        .mw_valid   (mw_valid),
        .mw_ready   (mw_ready),
        .mw_addr    (mw_addr),
        .mw_data    (mw_data),
        .mw_last    (mw_last)
    );

    // Queue of filled page reports for software.
    rxdma_fifo #(
        .WIDTH (REP_W),
        .DEPTH (RDY_DEPTH)
    ) u_rdy_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rdy_push),
        .din   (rdy_entry),
        .pop   (rdy_pop),
        .dout  (rdy_dout),
        .full  (rdy_full),
        .empty (rdy_empty)
    );

    assign rdy_head   = rdy_dout;
    assign rdy_valid  = !rdy_empty;
    assign rdy_addr   = rdy_head.base;
    assign rdy_status = rdy_head.status;

endmodule

// File: tb/sim_rxdma_top.sv
module sim_rxdma_top;

    localparam int CLK_PERIOD  = 10;
    localparam int HALF        = CLK_PERIOD / 2;
    localparam int PAGE_BYTES  = 4096;
    localparam int BURST_WORDS = 8;
    localparam int FREE_DEPTH  = 8;
    localparam int RDY_DEPTH   = 8;
    localparam int PW          = PAGE_BYTES / 4;
    localparam int MAXB        = 4096;
    localparam int WDOG        = 150000;

    logic        clk;
    logic        rst_n;
    logic        free_push;
    logic [31:0] free_addr;
    logic        free_full;
    logic        rx_valid;
    logic        rx_ready;
    logic [31:0] rx_data;
    logic        rx_last;
    logic        rx_err;
    logic        mw_valid;
    logic        mw_ready;
    logic [31:0] mw_addr;
    logic [31:0] mw_data;
    logic        mw_last;
    logic        rdy_valid;
    logic        rdy_pop;
    logic [31:0] rdy_addr;
    logic [31:0] rdy_status;

    rxdma_top #(
        .PAGE_BYTES  (PAGE_BYTES),
        .BURST_WORDS (BURST_WORDS),
        .FREE_DEPTH  (FREE_DEPTH),
        .RDY_DEPTH   (RDY_DEPTH)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .free_push  (free_push),
        .free_addr  (free_addr),
        .free_full  (free_full),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_err     (rx_err),
        .mw_valid   (mw_valid),
        .mw_ready   (mw_ready),
        .mw_addr    (mw_addr),
        .mw_data    (mw_data),
        .mw_last    (mw_last),
        .rdy_valid  (rdy_valid),
        .rdy_pop    (rdy_pop),
        .rdy_addr   (rdy_addr),
        .rdy_status (rdy_status)
    );

    initial clk = 1'b0;
    always #(HALF) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // Observed beats, captured one time unit before each rising edge.
    logic [31:0] got_addr [MAXB];
    logic [31:0] got_data [MAXB];
    logic        got_last [MAXB];
    int          got_n;
    int          rx_n;
    int          bp_viol;

    // Expected model built from the requirements.
    logic [31:0] pg [16];
    int          pg_n;
    int          cur_pg;
    int          cur_off;
    logic        cur_err;
    logic [31:0] exp_addr [MAXB];
    logic [31:0] exp_data [MAXB];
    logic        exp_last [MAXB];
    int          exp_n;
    logic [31:0] rq_addr [16];
    logic [31:0] rq_stat [16];
    int          rq_n;
    int          rq_rd;

    logic bp_en;
    int   cyc;

    // Master port stall pattern.
    always @(negedge clk) begin
        cyc++;
        mw_ready = bp_en ? ((cyc % 3) != 2) : 1'b1;
    end

    // Beat monitor.
    initial begin
        got_n = 0; rx_n = 0; bp_viol = 0; cyc = 0; bp_en = 1'b0;
        forever begin
            @(negedge clk);
            #(HALF - 1);
            if (mw_valid && mw_ready) begin
                if (got_n < MAXB) begin
                    got_addr[got_n] = mw_addr;
                    got_data[got_n] = mw_data;
                    got_last[got_n] = mw_last;
                end
                got_n++;
            end
            if (rx_valid && rx_ready) rx_n++;
            if (rx_ready && !mw_ready) bp_viol++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_stat(input int bytes, input bit last, input bit err);
        return {last, err, 6'b0, bytes[23:0]};
    endfunction

    task automatic clear_model();
        pg_n = 0; cur_pg = 0; cur_off = 0; cur_err = 1'b0;
        exp_n = 0; rq_n = 0; rq_rd = 0;
        got_n = 0; rx_n = 0; bp_viol = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_err = 1'b0;
        free_push = 1'b0; free_addr = '0; rdy_pop = 1'b0; bp_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
    endtask

    task automatic push_free(input logic [31:0] a);
        if (!free_full && pg_n < 16) begin
            pg[pg_n] = a;
            pg_n++;
        end
        free_push = 1'b1;
        free_addr = a;
        @(negedge clk);
        free_push = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] d, input bit last, input bit err);
        exp_addr[exp_n] = pg[cur_pg] + 32'(cur_off * 4);
        exp_data[exp_n] = d;
        exp_last[exp_n] = last || (cur_off == PW - 1) ||
                          ((cur_off % BURST_WORDS) == BURST_WORDS - 1);
        exp_n++;
        cur_err = cur_err | err;
        if (last || cur_off == PW - 1) begin
            rq_addr[rq_n] = pg[cur_pg];
            rq_stat[rq_n] = mk_stat((cur_off + 1) * 4, last, cur_err);
            rq_n++;
            cur_pg++;
            cur_off = 0;
            cur_err = 1'b0;
        end else begin
            cur_off++;
        end
        rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = err;
        forever begin
            #(HALF - 1);
            if (rx_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic send_block(input int n, input logic [31:0] seed, input int err_at);
        for (int i = 0; i < n; i++) begin
            send_word(seed ^ 32'(i), (i == n - 1), (i == err_at));
        end
    endtask

    task automatic probe_stall(input int cycles, input string tag);
        int  start;
        bit  saw;
        start = got_n;
        saw = 1'b0;
        rx_valid = 1'b1; rx_data = 32'hDEAD_0000; rx_last = 1'b1;
        repeat (cycles) begin
            #(HALF - 1);
            if (rx_ready) saw = 1'b1;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
        chk(!saw && got_n == start, tag, "rx_ready held low, no beat",
            32'(got_n - start), 32'd0);
    endtask

    task automatic pop_next(input string tag);
        int w;
        w = 0;
        while (!rdy_valid && w < 100) begin
            @(negedge clk);
            w++;
        end
        chk(rdy_valid, tag, "report available", {31'd0, rdy_valid}, 32'd1);
        if (rq_rd < rq_n) begin
            chk(rdy_addr == rq_addr[rq_rd], tag, "report page base", rdy_addr, rq_addr[rq_rd]);
            chk(rdy_status == rq_stat[rq_rd], tag, "report status", rdy_status, rq_stat[rq_rd]);
        end
        rdy_pop = 1'b1;
        @(negedge clk);
        rdy_pop = 1'b0;
        rq_rd++;
    endtask

    task automatic verify_beats(input string tag_ad, input string tag_last);
        int bad_ad;
        int bad_ls;
        bad_ad = -1;
        bad_ls = -1;
        chk(got_n == exp_n, tag_ad, "beat count", 32'(got_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (bad_ad < 0 && (got_addr[i] !== exp_addr[i] || got_data[i] !== exp_data[i]))
                bad_ad = i;
            if (bad_ls < 0 && got_last[i] !== exp_last[i])
                bad_ls = i;
        end
        chk(bad_ad < 0, tag_ad, "beat address/data",
            (bad_ad < 0) ? 32'd0 : got_addr[bad_ad], (bad_ad < 0) ? 32'd0 : exp_addr[bad_ad]);
        chk(bad_ls < 0, tag_last, "burst last flag",
            (bad_ls < 0) ? 32'd0 : 32'(bad_ls), 32'hFFFF_FFFF);
    endtask

    task automatic verify_reports(input string tag);
        while (rq_rd < rq_n) pop_next(tag);
        chk(!rdy_valid, tag, "no extra report", {31'd0, rdy_valid}, 32'd0);
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        do_reset();
        chk(!rx_ready, "R1", "rx_ready after reset", {31'd0, rx_ready}, 32'd0);
        chk(!mw_valid, "R1", "mw_valid after reset", {31'd0, mw_valid}, 32'd0);
        chk(!rdy_valid, "R1", "rdy_valid after reset", {31'd0, rdy_valid}, 32'd0);
        chk(!free_full, "R1", "free_full after reset", {31'd0, free_full}, 32'd0);
    endtask

    // R3: no free page holds off data; data offered later is not lost.
    task automatic t_no_page();
        do_reset();
        probe_stall(12, "R3");
        push_free(32'h0010_0000);
        send_block(4, 32'h3300_0000, -1);
        verify_beats("R3", "R5");
        verify_reports("R7");
    endtask

    // R4, R5, R7: short blocks each close their own page.
    task automatic t_short_blocks();
        do_reset();
        push_free(32'h0020_0000);
        push_free(32'h0031_0000);
        send_block(5, 32'h5500_0000, -1);
        send_block(10, 32'h6600_0000, -1);
        verify_beats("R4", "R5");
        verify_reports("R7");
    endtask

    // R8: error flag per page, cleared on the next page.
    task automatic t_error_flag();
        do_reset();
        push_free(32'h0040_0000);
        push_free(32'h0041_0000);
        send_block(3, 32'h8800_0000, 1);
        send_block(2, 32'h9900_0000, -1);
        verify_beats("R8", "R5");
        verify_reports("R8");
    endtask

    // R6, R4, R5: a block spanning three pages under master stalls.
    task automatic t_multi_page();
        do_reset();
        push_free(32'h0100_0000);
        push_free(32'h0200_0000);
        push_free(32'h0050_0000);
        bp_en = 1'b1;
        send_block(2100, 32'hA500_0000, -1);
        bp_en = 1'b0;
        @(negedge clk);
        chk(bp_viol == 0, "R4", "rx_ready while mw_ready low", 32'(bp_viol), 32'd0);
        chk(rx_n == got_n, "R4", "accepted words equal beats", 32'(got_n), 32'(rx_n));
        verify_beats("R4", "R5");
        verify_reports("R6");
    endtask

    // R6, R7: block that ends exactly on the last word of a page.
    task automatic t_exact_fit();
        do_reset();
        push_free(32'h0070_0000);
        push_free(32'h0071_0000);
        send_block(PW, 32'hC300_0000, -1);
        send_block(3, 32'hC400_0000, -1);
        verify_beats("R6", "R5");
        verify_reports("R6");
    endtask

    // R9: full report queue stops the next page until a pop.
    task automatic t_report_full();
        do_reset();
        for (int k = 0; k < RDY_DEPTH; k++) begin
            push_free(32'h0800_0000 + 32'(k * PAGE_BYTES));
            send_block(1, 32'hB000_0000 + 32'(k), -1);
        end
        push_free(32'h0900_0000);
        probe_stall(10, "R9");
        pop_next("R9");
        send_block(1, 32'hB0FF_0000, -1);
        verify_reports("R9");
        verify_beats("R9", "R5");
    endtask

    // R2: queue order and a dropped push while full.
    task automatic t_free_full();
        int k;
        do_reset();
        k = 0;
        while (!free_full && k < 20) begin
            push_free(32'h4000_0000 + 32'(k * PAGE_BYTES));
            k++;
        end
        chk(free_full, "R2", "free_full reached", {31'd0, free_full}, 32'd1);
        push_free(32'h7FFF_0000);
        for (int i = 0; i < pg_n; i++) begin
            send_block(1, 32'hD000_0000 + 32'(i), -1);
            pop_next("R2");
        end
        probe_stall(8, "R2");
        verify_beats("R2", "R5");
    endtask

    // R1: reset in the middle of a page discards it and the queued page.
    task automatic t_mid_reset();
        do_reset();
        push_free(32'h0A00_0000);
        push_free(32'h0B00_0000);
        send_word(32'hE000_0001, 1'b0, 1'b0);
        send_word(32'hE000_0002, 1'b0, 1'b0);
        send_word(32'hE000_0003, 1'b0, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        chk(!rdy_valid, "R1", "no report for discarded page", {31'd0, rdy_valid}, 32'd0);
        chk(!free_full, "R1", "free queue after reset", {31'd0, free_full}, 32'd0);
        probe_stall(8, "R1");
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_page();
        t_short_blocks();
        t_error_flag();
        t_multi_page();
        t_exact_fit();
        t_report_full();
        t_free_full();
        t_mid_reset();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule